// File: doc/BRIEF.md
# Triggered Snubber Pulse Generator

This block drives the gate of an active-clamp snubber switch on the secondary side of a bridge-type isolated converter. It watches one of two pairs of PWM drive signals. One pair is the two opposite-leg primary drives and the other is the two synchronous-rectifier drives. The block merges the chosen edges of that pair into one trigger. After a programmable delay it raises its output for a programmable on time, which is counted in coarse clock periods (for example 5 ns).

All four PWM inputs pass through a synchronizer. Each input is then compared with its own previous sample to find its edges. The source-pair select picks which two edge streams count, and the edge select picks rising or falling edges. The trigger is the OR of the two selected streams. A sequencer then walks through three states. **IDLE** waits for a trigger. **DELAY** counts out the delay. **ON** holds the output high for the width. There are four transitions:
- *launch*: IDLE to DELAY, or straight to ON when the delay is zero.
- *fire*: DELAY to ON when the delay count runs out.
- *expire*: ON to IDLE when the width count runs out.
- *abort*: any state to IDLE when the enable is low.

The delay and width settings are captured only while the sequencer is in IDLE.

Top module: `snub_pulse_gen`

## Requirements
- R1: After reset the output is low and no pulse appears until a trigger is seen.
- R2: With the source select at 0 (primary pair) and the edge select at 0 (rising), a rising edge on either primary input launches a pulse. Edges on the rectifier inputs have no effect.
- R3: With the source select at 1 (rectifier pair), a selected edge on either rectifier input launches a pulse. Edges on the primary inputs have no effect.
- R4: With the edge select at 1, only falling edges of the selected pair launch a pulse. Rising edges have no effect.
- R5: Count the clock edges that see the new input level, with the first such edge as edge 1. The output rises just after edge 3+D, where D is the delay setting (0 to 255).
- R6: The output stays high for exactly W clock cycles, where W is the width setting (1 to 255). W=1 gives a single-cycle pulse.
- R7: A width setting of 0 suppresses the pulse entirely.
- R8: A trigger that arrives while a delay or a pulse is in progress is ignored. It neither extends the pulse nor starts a second one.
- R9: Changes to the delay or width settings made during DELAY or ON do not alter the pulse in progress.
- R10: When the enable is low, the output goes low at once. The sequencer returns to IDLE on the next clock edge, and triggers seen while disabled launch nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Coarse timing clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| en | input | 1 | Block enable; low forces output low and sequencer to IDLE |
| pri_a | input | 1 | Primary drive, first leg |
| pri_b | input | 1 | Primary drive, opposite leg |
| rect_a | input | 1 | First synchronous-rectifier drive |
| rect_b | input | 1 | Second synchronous-rectifier drive |
| src_sel | input | 1 | 0 = primary pair, 1 = rectifier pair |
| edge_sel | input | 1 | 0 = rising edges, 1 = falling edges |
| dly_cfg | input | 8 | Delay from trigger to pulse, in clock periods |
| wid_cfg | input | 8 | Pulse on time, in clock periods |
| snub_out | output | 1 | Snubber gate pulse |

## Verification
The embedded properties watch the sequencer on every cycle. They check that a disabled block lands in IDLE, that an ON state with count left stays ON while its count steps down by one, and that a zero width leaves IDLE untouched. They also check that a zero delay goes straight to ON, that triggers in a busy state do not disturb it, that the captured width holds through DELAY, and that falling-edge triggers only appear when a selected input is low. The end-to-end latency through the synchronizer, the exact pulse widths at the extremes of the settings, and the isolation of the unselected pair can only be shown by the bench's scenarios. The same holds for mid-pulse retriggers, mid-pulse setting changes and enable aborts, which the bench observes at the output.

// File: rtl/snub_pkg.sv
package snub_pkg;

    // Sequencer states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_ON    = 2'd2
    } snub_state_t;

    // Which PWM pair feeds the trigger
    typedef enum logic {
        SRC_PRIMARY = 1'b0,
        SRC_RECT    = 1'b1
    } snub_src_t;

    // Which edge of the pair forms the trigger
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } snub_edge_t;

    // Input bit positions inside the synchronized bus
    localparam int unsigned IDX_PRI_A  = 0;
    localparam int unsigned IDX_PRI_B  = 1;
    localparam int unsigned IDX_RECT_A = 2;
    localparam int unsigned IDX_RECT_B = 3;
    localparam int unsigned NUM_PWM    = 4;

endpackage

// File: rtl/snub_sync.sv
module snub_sync #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/snub_edge.sv
module snub_edge
    import snub_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_PWM-1:0] pwm_sync,
    input  logic               src_sel,
    input  logic               edge_sel,
    output logic               trig
);

    logic [NUM_PWM-1:0] prev_q;
    logic [NUM_PWM-1:0] rise_v;
    logic [NUM_PWM-1:0] fall_v;
    logic [1:0]         pair_edges;
    logic [1:0]         pair_level;
    snub_src_t          src;
    snub_edge_t         pol;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= pwm_sync;
    end

    generate
        for (genvar i = 0; i < NUM_PWM; i++) begin : g_det
            assign rise_v[i] =  pwm_sync[i] & ~prev_q[i];
            assign fall_v[i] = ~pwm_sync[i] &  prev_q[i];
        end
    endgenerate

    always_comb begin
        src = snub_src_t'(src_sel);
        pol = snub_edge_t'(edge_sel);
        unique case (src)
            SRC_PRIMARY: begin
                pair_level = {pwm_sync[IDX_PRI_B], pwm_sync[IDX_PRI_A]};
                pair_edges = (pol == EDGE_RISE)
                           ? {rise_v[IDX_PRI_B], rise_v[IDX_PRI_A]}
                           : {fall_v[IDX_PRI_B], fall_v[IDX_PRI_A]};
            end
            SRC_RECT: begin
                pair_level = {pwm_sync[IDX_RECT_B], pwm_sync[IDX_RECT_A]};
                pair_edges = (pol == EDGE_RISE)
                           ? {rise_v[IDX_RECT_B], rise_v[IDX_RECT_A]}
                           : {fall_v[IDX_RECT_B], fall_v[IDX_RECT_A]};
            end
            default: begin
                pair_level = '0;
                pair_edges = '0;
            end
        endcase
        trig = |pair_edges;
    end

    // R4
    fall_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_sel && trig) |-> (pair_level != 2'b11));

endmodule

// File: rtl/snub_seq.sv
module snub_seq
    import snub_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             trig,
    input  logic [CNT_W-1:0] dly_cfg,
    input  logic [CNT_W-1:0] wid_cfg,
    output logic             snub_out
);

    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    snub_state_t      state_q, state_n;
    logic [CNT_W-1:0] cnt_q,   cnt_n;
    logic [CNT_W-1:0] wid_q;

    // State and counter register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // Width shadow: follows the setting only while idle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  wid_q <= '0;
        else if (state_q == ST_IDLE) wid_q <= wid_cfg;
    end

    // Next-state logic
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trig && (wid_cfg != CNT_ZERO)) begin
                    if (dly_cfg == CNT_ZERO) begin
                        state_n = ST_ON;
                        cnt_n   = wid_cfg - CNT_ONE;
                    end else begin
                        state_n = ST_DELAY;
                        cnt_n   = dly_cfg - CNT_ONE;
                    end
                end
            end
            ST_DELAY: begin
                if (cnt_q == CNT_ZERO) begin
                    state_n = ST_ON;
                    cnt_n   = wid_q - CNT_ONE;
                end else begin
                    cnt_n = cnt_q - CNT_ONE;
                end
            end
            ST_ON: begin
                if (cnt_q == CNT_ZERO) begin
                    state_n = ST_IDLE;
                    cnt_n   = CNT_ZERO;
                end else begin
                    cnt_n = cnt_q - CNT_ONE;
                end
            end
            default: begin
                state_n = ST_IDLE;
                cnt_n   = CNT_ZERO;
            end
        endcase
        if (!en) begin
            state_n = ST_IDLE;
            cnt_n   = CNT_ZERO;
        end
    end

    // Output decode
    always_comb begin
        snub_out = (state_q == ST_ON) && en;
    end

    // R10
    disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_q == ST_IDLE));

    // R6
    on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ON && cnt_q != CNT_ZERO && en)
        |=> (state_q == ST_ON && cnt_q == $past(cnt_q) - CNT_ONE));

    // R7
    zero_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && trig && wid_cfg == CNT_ZERO) |=> (state_q == ST_IDLE));

    // R5
    zero_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && en && trig && wid_cfg != CNT_ZERO && dly_cfg == CNT_ZERO)
        |=> (state_q == ST_ON));

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && trig && en && cnt_q != CNT_ZERO) |=> $stable(state_q));

    // R9
    width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DELAY && en) |=> $stable(wid_q));

endmodule

// File: rtl/snub_pulse_gen.sv
module snub_pulse_gen
    import snub_pkg::*;
#(
    parameter int unsigned CNT_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             pri_a,
    input  logic             pri_b,
    input  logic             rect_a,
    input  logic             rect_b,
    input  logic             src_sel,
    input  logic             edge_sel,
    input  logic [CNT_W-1:0] dly_cfg,
    input  logic [CNT_W-1:0] wid_cfg,
    output logic             snub_out
);

    logic [NUM_PWM-1:0] pwm_raw;
    logic [NUM_PWM-1:0] pwm_sync;
    logic               trig;

    always_comb begin
        pwm_raw             = '0;
        pwm_raw[IDX_PRI_A]  = pri_a;
        pwm_raw[IDX_PRI_B]  = pri_b;
        pwm_raw[IDX_RECT_A] = rect_a;
        pwm_raw[IDX_RECT_B] = rect_b;
    end

    snub_sync #(
        .WIDTH  (NUM_PWM),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pwm_raw),
        .sync_out (pwm_sync)
    );

    snub_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwm_sync (pwm_sync),
        .src_sel  (src_sel),
        .edge_sel (edge_sel),
        .trig     (trig)
    );

    snub_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .trig     (trig),
        .dly_cfg  (dly_cfg),
        .wid_cfg  (wid_cfg),
        .snub_out (snub_out)
    );

endmodule

// File: tb/snub_pulse_gen_test.sv
module snub_pulse_gen_test;

    localparam time CLK_HALF = 4ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       pri_a = 1'b0, pri_b = 1'b0, rect_a = 1'b0, rect_b = 1'b0;
    logic       src_sel = 1'b0, edge_sel = 1'b0;
    logic [7:0] dly_cfg = 8'd0, wid_cfg = 8'd1;
    logic       snub_out;

    int checks = 0;
    int errors = 0;

    always #CLK_HALF clk = ~clk;

    snub_pulse_gen uut (
        .clk(clk), .rst_n(rst_n), .en(en),
        .pri_a(pri_a), .pri_b(pri_b), .rect_a(rect_a), .rect_b(rect_b),
        .src_sel(src_sel), .edge_sel(edge_sel),
        .dly_cfg(dly_cfg), .wid_cfg(wid_cfg), .snub_out(snub_out)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Walk ncyc falling edges after a stimulus; optional poke at cycle poke_at.
    // poke_kind 1: raise pri_b. 2: change settings to wid=20, dly=0.
    task automatic run_window(input int ncyc, input int poke_at, input int poke_kind,
                              output int first_hi, output int width, output int pulses);
        logic last = 1'b0;
        first_hi = -1; width = 0; pulses = 0;
        for (int n = 1; n <= ncyc; n++) begin
            @(negedge clk);
            if (snub_out) begin
                width++;
                if (!last) begin
                    pulses++;
                    if (first_hi < 0) first_hi = n;
                end
            end
            last = snub_out;
            if (n == poke_at) begin
                if (poke_kind == 1) pri_b = 1'b1;
                if (poke_kind == 2) begin wid_cfg = 8'd20; dly_cfg = 8'd0; end
            end
        end
    endtask

    task automatic settle();
        @(negedge clk);
        edge_sel = 1'b0;
        pri_a = 0; pri_b = 0; rect_a = 0; rect_b = 0;
        repeat (8) @(negedge clk);
    endtask

    task automatic t_reset();
        int f, w, p;
        run_window(20, 0, 0, f, w, p);
        chk(p == 0, "R1 no pulse after reset", p, 0);
        chk(snub_out == 1'b0, "R1 output low", snub_out, 0);
    endtask

    task automatic t_primary(input int d, input int w, input bit use_b);
        int f, wd, p;
        @(negedge clk);
        dly_cfg = d[7:0]; wid_cfg = w[7:0]; src_sel = 0; edge_sel = 0;
        if (use_b) pri_b = 1'b1; else pri_a = 1'b1;
        run_window(d + w + 20, 0, 0, f, wd, p);
        chk(p == 1, "R2 one pulse from primary edge", p, 1);
        chk(f == 3 + d, "R5 delay latency", f, 3 + d);
        chk(wd == w, "R6 pulse width", wd, w);
        settle();
    endtask

    task automatic t_rect_ignored();
        int f, w, p;
        @(negedge clk);
        dly_cfg = 1; wid_cfg = 4; src_sel = 0;
        rect_a = 1'b1;
        run_window(30, 10, 0, f, w, p);
        chk(p == 0, "R2 rectifier edge ignored in primary mode", p, 0);
        settle();
    endtask

    task automatic t_rect_mode();
        int f, w, p;
        @(negedge clk);
        dly_cfg = 2; wid_cfg = 5; src_sel = 1;
        rect_b = 1'b1;
        run_window(30, 0, 0, f, w, p);
        chk(p == 1 && f == 5 && w == 5, "R3 rectifier pair triggers", f, 5);
        settle();
        pri_a = 1'b1;
        run_window(30, 0, 0, f, w, p);
        chk(p == 0, "R3 primary edge ignored in rectifier mode", p, 0);
        settle();
        src_sel = 0;
    endtask

    task automatic t_falling();
        int f, w, p;
        @(negedge clk);
        dly_cfg = 3; wid_cfg = 2; src_sel = 0; edge_sel = 1;
        pri_a = 1'b1;
        run_window(30, 0, 0, f, w, p);
        chk(p == 0, "R4 rising edge ignored in falling mode", p, 0);
        pri_a = 1'b0;
        run_window(30, 0, 0, f, w, p);
        chk(p == 1 && f == 6, "R4 falling edge triggers", f, 6);
        chk(w == 2, "R6 width in falling mode", w, 2);
        settle();
    endtask

    task automatic t_zero_width();
        int f, w, p;
        @(negedge clk);
        dly_cfg = 0; wid_cfg = 0;
        pri_a = 1'b1;
        run_window(30, 0, 0, f, w, p);
        chk(p == 0, "R7 zero width suppresses pulse", p, 0);
        settle();
    endtask

    task automatic t_retrigger();
        int f, w, p;
        @(negedge clk);
        dly_cfg = 4; wid_cfg = 10;
        pri_a = 1'b1;
        run_window(60, 9, 1, f, w, p);
        chk(p == 1 && w == 10, "R8 retrigger during ON ignored", w, 10);
        settle();
        dly_cfg = 6; wid_cfg = 3;
        pri_a = 1'b1;
        run_window(60, 2, 1, f, w, p);
        chk(p == 1 && f == 9, "R8 retrigger during DELAY ignored", f, 9);
        chk(w == 3, "R8 width unchanged by retrigger", w, 3);
        settle();
    endtask

    task automatic t_cfg_hold();
        int f, w, p;
        @(negedge clk);
        dly_cfg = 3; wid_cfg = 6;
        pri_a = 1'b1;
        run_window(60, 4, 2, f, w, p);
        chk(f == 6, "R9 delay held after setting change", f, 6);
        chk(p == 1 && w == 6, "R9 width held after setting change", w, 6);
        settle();
    endtask

    task automatic t_enable();
        int f, w, p;
        @(negedge clk);
        dly_cfg = 0; wid_cfg = 20;
        pri_a = 1'b1;
        repeat (5) @(negedge clk);
        chk(snub_out == 1'b1, "R10 pulse running before disable", snub_out, 1);
        en = 1'b0;
        #1;
        chk(snub_out == 1'b0, "R10 output low at once when disabled", snub_out, 0);
        @(negedge clk);
        en = 1'b1;
        run_window(40, 0, 0, f, w, p);
        chk(p == 0, "R10 aborted pulse does not resume", p, 0);
        settle();
        en = 1'b0;
        pri_b = 1'b1;
        repeat (10) @(negedge clk);
        en = 1'b1;
        run_window(30, 0, 0, f, w, p);
        chk(p == 0, "R10 trigger while disabled ignored", p, 0);
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        en = 1'b1;
        t_reset();
        t_primary(0, 1, 1'b0);
        t_primary(5, 3, 1'b1);
        t_primary(255, 255, 1'b0);
        t_primary(1, 2, 1'b1);
        t_rect_ignored();
        t_rect_mode();
        t_falling();
        t_zero_width();
        t_retrigger();
        t_cfg_hold();
        t_enable();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8ns * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule